// File: doc/BRIEF.md
# Circular Address Generator with Shadow Register Banks

This block produces post-modify indirect addresses for a data memory. It holds a set of register groups. Each group has an index (the current pointer), a base, a length and a modify value. Any group can run as a hardware circular buffer. When the pointer steps outside the buffer window, it is folded back into the window in the same cycle, so software spends no extra cycles on wraparound. The buffer window may begin at any address and span any length. No alignment is required.

Every group exists twice, in a primary bank and a secondary bank. A single mode bit picks which bank the block uses for accesses, register writes and register reads. An interrupt handler can therefore switch to a fresh set of pointers in one write and return later to the untouched originals. The block talks to the outside through four paths:

- a register write port;
- a combinational register read port;
- a one-bit mode write;
- an address request that names an index group and a separately chosen modify register.

The address is returned one cycle after the request, together with a valid strobe.

Top module: `circ_agen`

## Requirements
- R1: After reset the primary bank is active, `addr_valid` is low, and every register reads back as zero.
- R2: A request in cycle t drives `addr_valid` high in cycle t+1, and `addr_out` equals the active index register of group `req_isel` as it was before the request. A cycle with no request leaves `addr_valid` low.
- R3: With a length of zero, a request writes index + modify (modulo 2^32) back into the index register. The modify value is treated as signed two's complement. This is plain linear post-modify.
- R4: With a nonzero length L and base B, if index + modify is at or above B+L, the stored index becomes index + modify − L.
- R5: With a nonzero length, if index + modify falls below B, the stored index becomes index + modify + L.
- R6: Base and length take any value, with no alignment rule. A buffer at an odd, unaligned base wraps correctly.
- R7: A register write uses `wr_kind` 0 for index, 1 for modify, 2 for base and 3 for length. A write of kind 2 also loads the index register of the same group with the same value.
- R8: When the mode bit is 1, writes, reads and requests all use the secondary bank; when it is 0 they use the primary bank. Switching banks leaves the contents of both banks unchanged.
- R9: A mode write takes effect from the following cycle. A request in the same cycle as the mode write still uses the previously active bank.
- R10: If a register write and a request hit the same index register in the same cycle, the written value is stored and the post-modify result is discarded. The address still presents the old index.
- R11: The modify register is chosen by `req_msel`, independently of the index group chosen by `req_isel`. The buffer window is taken from group `req_isel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (release synchronised inside) |
| mode_wr_en | input | 1 | Load the bank-select mode bit |
| mode_wr_data | input | 1 | New mode bit: 0 primary, 1 secondary |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind: 0 index, 1 modify, 2 base, 3 length |
| wr_sel | input | GSEL_W (4) | Group written |
| wr_data | input | AW (32) | Write data |
| rd_kind | input | 2 | Register kind read back |
| rd_sel | input | GSEL_W (4) | Group read back |
| rd_data | output | AW (32) | Read data from the active bank (combinational) |
| req_valid | input | 1 | Address request |
| req_isel | input | GSEL_W (4) | Index/base/length group for the request |
| req_msel | input | GSEL_W (4) | Modify register for the request |
| addr_out | output | AW (32) | Generated address |
| addr_valid | output | 1 | `addr_out` is valid this cycle |

## Verification
The bench carries its own model of both banks and predicts the address stream and the read port every cycle.

A wrong wrap decision or a wrong bank select corrupts only internal state at first. The stored index is wrong, but nothing on the ports shows it yet. The error becomes visible on `addr_out` at the next request to the same group, one cycle after that request. It is also visible at once on `rd_data` whenever the read port points at the damaged register.

For this reason the bench sweeps the read port across groups and kinds while it issues requests. Repeated requests on short buffers push every wrap case onto the ports within a few cycles.

// File: rtl/circ_agen_pkg.sv
package circ_agen_pkg;
  typedef enum logic [1:0] {
    KIND_IDX  = 2'd0,
    KIND_MOD  = 2'd1,
    KIND_BASE = 2'd2,
    KIND_LEN  = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/circ_agen_rst_sync.sv
module circ_agen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/circ_agen_wrap.sv
module circ_agen_wrap #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] mod,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);
  localparam int WW = AW + 2;

  logic signed [WW-1:0] sum_w;
  logic signed [WW-1:0] lim_w;
  logic signed [WW-1:0] base_w;
  logic [AW-1:0]        sum_n;
  logic                 above;
  logic                 below;
  logic                 circ;

  always_comb begin
    sum_w  = $signed({2'b00, idx}) + $signed({{2{mod[AW-1]}}, mod});
    base_w = $signed({2'b00, base});
    lim_w  = base_w + $signed({2'b00, len});
    sum_n  = idx + mod;
    circ   = (len != '0);
    above  = circ && (sum_w >= lim_w);
    below  = circ && (sum_w < base_w);
    if (above)      nxt = sum_n - len;
    else if (below) nxt = sum_n + len;
    else            nxt = sum_n;
  end
endmodule

// File: rtl/circ_agen_regbank.sv
module circ_agen_regbank
  import circ_agen_pkg::*;
#(
  parameter int AW     = 32,
  parameter int GROUPS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [$clog2(GROUPS)-1:0] wr_sel,
  input  logic [AW-1:0]     wr_data,
  input  logic [1:0]        rd_kind,
  input  logic [$clog2(GROUPS)-1:0] rd_sel,
  output logic [AW-1:0]     rd_data,
  input  logic              acc_en,
  input  logic [$clog2(GROUPS)-1:0] acc_isel,
  input  logic [$clog2(GROUPS)-1:0] acc_msel,
  input  logic [AW-1:0]     upd_idx,
  output logic [AW-1:0]     acc_idx,
  output logic [AW-1:0]     acc_mod,
  output logic [AW-1:0]     acc_base,
  output logic [AW-1:0]     acc_len
);
  localparam int GSEL_W = $clog2(GROUPS);
  localparam int SLOTS  = 2 * GROUPS;
  localparam int SLOT_W = GSEL_W + 1;

  reg_kind_e         wr_k;
  reg_kind_e         rd_k;
  logic [SLOT_W-1:0] wr_slot;
  logic [SLOT_W-1:0] rd_slot;
  logic [SLOT_W-1:0] ai_slot;
  logic [SLOT_W-1:0] am_slot;

  logic [AW-1:0] idx_arr  [SLOTS];
  logic [AW-1:0] mod_arr  [SLOTS];
  logic [AW-1:0] base_arr [SLOTS];
  logic [AW-1:0] len_arr  [SLOTS];

  always_comb begin
    wr_k    = reg_kind_e'(wr_kind);
    rd_k    = reg_kind_e'(rd_kind);
    wr_slot = {bank, wr_sel};
    rd_slot = {bank, rd_sel};
    ai_slot = {bank, acc_isel};
    am_slot = {bank, acc_msel};
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic          wr_hit;
    logic          acc_hit;
    logic          idx_en, mod_en, base_en, len_en;
    logic [AW-1:0] idx_d;
    logic [AW-1:0] idx_r, mod_r, base_r, len_r;

    always_comb begin
      wr_hit  = wr_en && (wr_slot == SLOT_W'(s));
      acc_hit = acc_en && (ai_slot == SLOT_W'(s));
      mod_en  = wr_hit && (wr_k == KIND_MOD);
      base_en = wr_hit && (wr_k == KIND_BASE);
      len_en  = wr_hit && (wr_k == KIND_LEN);
      idx_en  = acc_hit || (wr_hit && (wr_k == KIND_IDX || wr_k == KIND_BASE));
      if (wr_hit && (wr_k == KIND_IDX || wr_k == KIND_BASE)) idx_d = wr_data;
      else                                                   idx_d = upd_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_r  <= '0;
        mod_r  <= '0;
        base_r <= '0;
        len_r  <= '0;
      end else begin
        if (idx_en)  idx_r  <= idx_d;
        if (mod_en)  mod_r  <= wr_data;
        if (base_en) base_r <= wr_data;
        if (len_en)  len_r  <= wr_data;
      end
    end

    assign idx_arr[s]  = idx_r;
    assign mod_arr[s]  = mod_r;
    assign base_arr[s] = base_r;
    assign len_arr[s]  = len_r;
  end

  always_comb begin
    unique case (rd_k)
      KIND_IDX:  rd_data = idx_arr[rd_slot];
      KIND_MOD:  rd_data = mod_arr[rd_slot];
      KIND_BASE: rd_data = base_arr[rd_slot];
      default:   rd_data = len_arr[rd_slot];
    endcase
    acc_idx  = idx_arr[ai_slot];
    acc_base = base_arr[ai_slot];
    acc_len  = len_arr[ai_slot];
    acc_mod  = mod_arr[am_slot];
  end

  // R7
  base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_k == KIND_BASE) |=>
      (idx_arr[$past(wr_slot)] == $past(wr_data)) &&
      (base_arr[$past(wr_slot)] == $past(wr_data)));
endmodule

// File: rtl/circ_agen.sv
module circ_agen #(
  parameter int AW     = 32,
  parameter int GROUPS = 16,
  parameter int GSEL_W = $clog2(GROUPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr_en,
  input  logic              mode_wr_data,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [GSEL_W-1:0] wr_sel,
  input  logic [AW-1:0]     wr_data,
  input  logic [1:0]        rd_kind,
  input  logic [GSEL_W-1:0] rd_sel,
  output logic [AW-1:0]     rd_data,
  input  logic              req_valid,
  input  logic [GSEL_W-1:0] req_isel,
  input  logic [GSEL_W-1:0] req_msel,
  output logic [AW-1:0]     addr_out,
  output logic              addr_valid
);
  logic          srst_n;
  logic          bank_q, bank_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          vld_q, vld_d;
  logic [AW-1:0] cur_idx, cur_mod, cur_base, cur_len, nxt_idx;

  circ_agen_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (srst_n)
  );

  circ_agen_regbank #(.AW(AW), .GROUPS(GROUPS)) u_bank (
    .clk      (clk),
    .rst_n    (srst_n),
    .bank     (bank_q),
    .wr_en    (wr_en),
    .wr_kind  (wr_kind),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_kind  (rd_kind),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .acc_en   (req_valid),
    .acc_isel (req_isel),
    .acc_msel (req_msel),
    .upd_idx  (nxt_idx),
    .acc_idx  (cur_idx),
    .acc_mod  (cur_mod),
    .acc_base (cur_base),
    .acc_len  (cur_len)
  );

  circ_agen_wrap #(.AW(AW)) u_wrap (
    .idx  (cur_idx),
    .mod  (cur_mod),
    .base (cur_base),
    .len  (cur_len),
    .nxt  (nxt_idx)
  );

  always_comb begin
    bank_d = mode_wr_en ? mode_wr_data : bank_q;
    addr_d = req_valid ? cur_idx : addr_q;
    vld_d  = req_valid;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      bank_q <= 1'b0;
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      bank_q <= bank_d;
      vld_q  <= vld_d;
      if (req_valid) addr_q <= addr_d;
    end
  end

  assign addr_out   = addr_q;
  assign addr_valid = vld_q;

  logic [AW-1:0] a_off, a_mag, a_noff;
  logic          a_inwin;
  always_comb begin
    a_off   = cur_idx - cur_base;
    a_noff  = nxt_idx - cur_base;
    a_mag   = cur_mod[AW-1] ? (~cur_mod + 1'b1) : cur_mod;
    a_inwin = (cur_len != '0) && (cur_idx >= cur_base) && (a_off < cur_len) && (a_mag <= cur_len);
  end

  // R2
  addr_out_chk: assert property (@(posedge clk) disable iff (!srst_n)
    req_valid |=> addr_valid && (addr_out == $past(cur_idx)));

  // R4
  wrap_window_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && a_inwin) |-> (nxt_idx >= cur_base) && (a_noff < cur_len));

  // R3
  linear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && cur_len == '0) |-> (nxt_idx == cur_idx + cur_mod));

  // R9
  bank_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !mode_wr_en |=> $stable(bank_q));
endmodule

// File: tb/circ_agen_tb.sv
module circ_agen_tb;
  localparam int AW = 32;
  localparam int G  = 16;
  localparam int GW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_wr_en, mode_wr_data, wr_en, req_valid;
  logic [1:0] wr_kind, rd_kind;
  logic [GW-1:0] wr_sel, rd_sel, req_isel, req_msel;
  logic [AW-1:0] wr_data, rd_data, addr_out;
  logic addr_valid;

  always #5 clk = ~clk;

  circ_agen u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_kind(rd_kind), .rd_sel(rd_sel), .rd_data(rd_data),
    .req_valid(req_valid), .req_isel(req_isel), .req_msel(req_msel),
    .addr_out(addr_out), .addr_valid(addr_valid)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [AW-1:0] m_reg [2][4][G];
  bit            m_mode;
  bit            e_valid;
  logic [AW-1:0] e_addr;

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] next_index(logic [AW-1:0] i, logic [AW-1:0] m, logic [AW-1:0] b, logic [AW-1:0] l);
    longint n;
    n = longint'(i) + longint'($signed(m));
    if (l != 0) begin
      if (n >= longint'(b) + longint'(l)) n = n - longint'(l);
      else if (n < longint'(b))           n = n + longint'(l);
    end
    return n[AW-1:0];
  endfunction

  task automatic clear_inputs();
    mode_wr_en = 0; mode_wr_data = 0; wr_en = 0; wr_kind = 0; wr_sel = 0;
    wr_data = 0; req_valid = 0; req_isel = 0; req_msel = 0;
  endtask

  task automatic cyc(input string tag);
    bit ob;
    @(posedge clk);
    ob = m_mode;
    e_valid = req_valid;
    if (req_valid) begin
      e_addr = m_reg[ob][0][req_isel];
      m_reg[ob][0][req_isel] = next_index(m_reg[ob][0][req_isel], m_reg[ob][1][req_msel],
                                          m_reg[ob][2][req_isel], m_reg[ob][3][req_isel]);
    end
    if (wr_en) begin
      m_reg[ob][wr_kind][wr_sel] = wr_data;
      if (wr_kind == 2'd2) m_reg[ob][0][wr_sel] = wr_data;
    end
    if (mode_wr_en) m_mode = mode_wr_data;
    @(negedge clk);
    check(tag, {31'd0, addr_valid}, {31'd0, e_valid}, "addr_valid");
    if (e_valid) check(tag, addr_out, e_addr, "addr_out");
    check(tag, rd_data, m_reg[m_mode][rd_kind][rd_sel], "rd_data");
    clear_inputs();
  endtask

  task automatic wr(input logic [1:0] k, input int g, input logic [AW-1:0] d, input string tag);
    wr_en = 1; wr_kind = k; wr_sel = GW'(g); wr_data = d;
    rd_kind = k; rd_sel = GW'(g);
    cyc(tag);
  endtask

  task automatic acc(input int g, input int m, input string tag);
    req_valid = 1; req_isel = GW'(g); req_msel = GW'(m);
    rd_kind = 0; rd_sel = GW'(g);
    cyc(tag);
  endtask

  task automatic set_mode(input bit v, input string tag);
    mode_wr_en = 1; mode_wr_data = v;
    cyc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 4; k++)
        for (int g = 0; g < G; g++) m_reg[b][k][g] = '0;
    m_mode = 0; e_valid = 0; e_addr = '0;
    clear_inputs();
    rd_kind = 0; rd_sel = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state across kinds and groups
    check("R1", {31'd0, addr_valid}, 32'd0, "addr_valid");
    for (int k = 0; k < 4; k++) begin
      rd_kind = 2'(k); rd_sel = GW'(k * 5);
      #1 check("R1", rd_data, 32'd0, "rd_data");
    end
    cyc("R1");

    // R6/R7: unaligned base loads index
    wr(2'd2, 3, 32'd1003, "R7");
    rd_kind = 0; rd_sel = 3; #1 check("R7", rd_data, 32'd1003, "index after base write");
    wr(2'd3, 3, 32'd10, "R6");
    wr(2'd1, 2, 32'd4, "R11");
    // R4 forward wrap, modify chosen from another group (R11)
    acc(3, 2, "R4"); acc(3, 2, "R4"); acc(3, 2, "R4"); acc(3, 2, "R4");
    cyc("R2");
    rd_kind = 0; rd_sel = 3; #1 check("R4", rd_data, 32'd1009, "index after wrap");
    // R5 backward wrap with negative modify
    wr(2'd1, 5, 32'hFFFF_FFFD, "R5");
    acc(3, 5, "R5"); acc(3, 5, "R5"); acc(3, 5, "R5"); acc(3, 5, "R5");
    // R3 linear, wraps modulo 2^32
    wr(2'd2, 0, 32'h10, "R3");
    wr(2'd1, 1, 32'hFFFF_FFE0, "R3");
    acc(0, 1, "R3"); acc(0, 1, "R3");
    rd_kind = 0; rd_sel = 0; #1 check("R3", rd_data, 32'hFFFF_FFD0, "linear index");
    // R9: access in same cycle as mode write uses primary
    mode_wr_en = 1; mode_wr_data = 1; req_valid = 1; req_isel = 3; req_msel = 2;
    cyc("R9");
    // R8: secondary bank starts empty and is separate
    rd_kind = 2; rd_sel = 3; #1 check("R8", rd_data, 32'd0, "secondary base");
    wr(2'd2, 3, 32'd77, "R8");
    wr(2'd3, 3, 32'd3, "R8");
    wr(2'd1, 2, 32'd1, "R8");
    acc(3, 2, "R8"); acc(3, 2, "R8"); acc(3, 2, "R8"); acc(3, 2, "R8");
    set_mode(0, "R8");
    rd_kind = 2; rd_sel = 3; #1 check("R8", rd_data, 32'd1003, "primary base kept");
    rd_kind = 1; rd_sel = 2; #1 check("R8", rd_data, 32'd4, "primary modify kept");
    acc(3, 2, "R8");
    // R10: write and access on same index register
    wr_en = 1; wr_kind = 0; wr_sel = 3; wr_data = 32'd1006;
    req_valid = 1; req_isel = 3; req_msel = 2; rd_kind = 0; rd_sel = 3;
    cyc("R10");
    rd_kind = 0; rd_sel = 3; #1 check("R10", rd_data, 32'd1006, "write wins");
    acc(3, 2, "R10");

    // R2: random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int g;
      g = $urandom_range(0, 3);
      if ($urandom_range(0, 19) == 0) begin
        mode_wr_en = 1; mode_wr_data = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1; wr_kind = 2'($urandom_range(1, 3)); wr_sel = GW'(g);
        case (wr_kind)
          2'd1: wr_data = 32'($urandom_range(0, 6)) - 32'd3;
          2'd2: wr_data = 32'($urandom_range(0, 5000));
          default: wr_data = 32'($urandom_range(0, 9));
        endcase
      end
      if ($urandom_range(0, 2) != 0) begin
        req_valid = 1; req_isel = GW'($urandom_range(0, 3)); req_msel = GW'($urandom_range(0, 3));
      end
      rd_kind = 2'($urandom_range(0, 3)); rd_sel = GW'($urandom_range(0, 3));
      cyc("R2");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule